// File: doc/BRIEF.md
# Zero-turnaround synchronous SRAM command engine

This block is a synthesizable model of a pipelined synchronous SRAM whose data bus needs no idle cycle between reads and writes. Each enabled rising clock edge samples three chip selects, advance/load, read/write, one write enable per byte lane and output enable. It decodes them into a deselect, a continue-deselect, a read, a dummy read, a write, a write abort or a burst continuation. A clock-enable input that is high holds the whole pipeline still for that edge.

A load cycle starts a burst at the presented address. Continue cycles then step a 2-bit counter through four words. The step order is linear or interleaved. The read or write type of a burst is fixed when the burst begins. Read data is registered one clock after the address edge. Write data is taken from the data input one enabled edge after its command, so a read can follow a write at once. A write to a word that is being read on the same edge is forwarded to the read.

Top module: `sram_cmd_engine`

## Requirements
- R1: After reset `dq_oe` is 0, and it stays 0 until a read has been loaded with all chip selects active and `out_en_n` low. Continue cycles before any such read do not drive the bus.
- R2: A load cycle (`adv`=0) with `sel0_n`=1, `sel1`=0 or `sel2_n`=1 is a deselect, and `dq_oe` is 0 after that edge. Continue cycles that follow a deselect store nothing, even when `wr_n`=0 and all byte enables are low.
- R3: A read load (`adv`=0, `sel0_n`=0, `sel1`=1, `sel2_n`=0, `wr_n`=1, `out_en_n`=0) puts the word at `addr` on `dq_o` with `dq_oe`=1 after that edge. Reads may follow each other on consecutive cycles.
- R4: A write load (`wr_n`=0) takes its data from `dq_i` at the next enabled edge and stores it at `addr`. Writes may follow each other on consecutive cycles.
- R5: `byte_wr_n[i]`=0 writes lane i, which is bits [9i+8:9i]. A lane whose enable is 1 keeps its old contents.
- R6: A write cycle with `byte_wr_n`=4'b1111 is an abort. Nothing is stored and `dq_oe` stays 0.
- R7: A read load with `out_en_n`=1 is a dummy read. The bus is not driven after it, nor after the continue cycles of that burst, even if `out_en_n` later goes low.
- R8: A continue cycle (`adv`=1) steps the burst address and keeps the type of its burst, whatever `wr_n` is. The low two address bits follow start+k mod 4 when `lin_burst`=1 and start XOR k when `lin_burst`=0, where k is 1, 2 or 3. The upper bits do not change.
- R9: With `clk_en_n`=1 an edge changes nothing. A bus that was driving read data keeps the same data, the bus of a write stays off, and a pending write waits and takes its data at the next enabled edge.
- R10: After a write cycle `dq_oe` is 0 even when `out_en_n` is low.
- R11: `out_en_n`=1 forces `dq_oe` to 0 at once, without a clock. Returning it to 0 restores driving of the held read data.
- R12: A read issued on the edge that takes the data of a write to the same address returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| clk_en_n | input | 1 | Clock enable, low = edge takes effect |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = continue burst, 0 = load new command |
| wr_n | input | 1 | On a load: 0 = write, 1 = read |
| byte_wr_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| lin_burst | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | AW | Word address |
| dq_i | input | DW | Write data bus |
| dq_o | output | DW | Read data bus |
| dq_oe | output | 1 | Tri-state enable for `dq_o` |

## Verification
The bench places a write and then a read of the same word on adjacent edges. A design without forwarding would return the stale word there. It runs bursts in both orders from a start address that is not aligned, and drives `wr_n` the opposite way during the continue cycles. This exposes a design that wraps the wrong bits or re-reads the type on every cycle. It holds `clk_en_n` high both while the bus is driving and while a write is pending. A design that lets an inhibited edge clear the read flag, or that commits the junk data present then, is caught. Dummy reads, aborts and continues after a deselect are each followed by read-back, to show that a design treating them as real accesses has driven the bus or corrupted memory.

// File: rtl/sram_eng_pkg.sv
package sram_eng_pkg;

   typedef enum logic [1:0] {
      BS_IDLE,
      BS_READ,
      BS_DUMMY,
      BS_WRITE
   } burst_e;

   typedef enum logic [2:0] {
      OP_INHIBIT,
      OP_DESEL,
      OP_CDESEL,
      OP_READ,
      OP_DUMMY,
      OP_WRITE,
      OP_ABORT
   } op_e;

   // low two address bits of burst step k from a given start
   function automatic logic [1:0] burst_low(logic [1:0] start, logic [1:0] step, logic lin);
      return lin ? (start + step) : (start ^ step);
   endfunction

endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
   import sram_eng_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             clk_en_n,
   input  logic             sel0_n,
   input  logic             sel1,
   input  logic             sel2_n,
   input  logic             adv,
   input  logic             wr_n,
   input  logic [LANES-1:0] byte_wr_n,
   input  logic             out_en_n,
   input  burst_e           state,
   output op_e              op,
   output burst_e           state_nx,
   output logic             load
);

   logic no_lanes;
   logic selected;

   assign no_lanes = &byte_wr_n;
   assign selected = !sel0_n && sel1 && !sel2_n;

   always_comb begin
      op       = OP_INHIBIT;
      state_nx = state;
      load     = 1'b0;
      if (!clk_en_n) begin
         if (!adv) begin
            load = 1'b1;
            if (!selected) begin
               op       = OP_DESEL;
               state_nx = BS_IDLE;
            end else if (wr_n) begin
               op       = out_en_n ? OP_DUMMY : OP_READ;
               state_nx = out_en_n ? BS_DUMMY : BS_READ;
            end else begin
               op       = no_lanes ? OP_ABORT : OP_WRITE;
               state_nx = BS_WRITE;
            end
         end else begin
            case (state)
               BS_READ:  op = OP_READ;
               BS_DUMMY: op = OP_DUMMY;
               BS_WRITE: op = no_lanes ? OP_ABORT : OP_WRITE;
               default:  op = OP_CDESEL;
            endcase
         end
      end
   end

endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
   import sram_eng_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          load,
   input  logic          lin,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] eff_addr
);

   logic [AW-1:0] base_q;
   logic [1:0]    cnt_q;
   logic [1:0]    cnt_nx;

   assign cnt_nx = cnt_q + 2'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (step) begin
         if (load) begin
            base_q <= addr_in;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= cnt_nx;
         end
      end
   end

   always_comb begin
      if (load) eff_addr = addr_in;
      else      eff_addr = {base_q[AW-1:2], burst_low(base_q[1:0], cnt_nx, lin)};
   end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int DEPTH  = 256,
   localparam int AW    = $clog2(DEPTH),
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    wa,
   input  logic [LANES-1:0] wbe,
   input  logic [DW-1:0]    wd,
   input  logic [AW-1:0]    ra,
   output logic [DW-1:0]    rd
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];
      logic              hit;

      assign hit = we && wbe[g] && (wa == ra);

      always_ff @(posedge clk) begin
         if (we && wbe[g]) store[wa] <= wd[g*LANE_W +: LANE_W];
      end

      assign rd[g*LANE_W +: LANE_W] = hit ? wd[g*LANE_W +: LANE_W] : store[ra];
   end

endmodule

// File: rtl/sram_cmd_engine.sv
module sram_cmd_engine
   import sram_eng_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int DEPTH  = 256,
   localparam int AW    = $clog2(DEPTH),
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en_n,
   input  logic             sel0_n,
   input  logic             sel1,
   input  logic             sel2_n,
   input  logic             adv,
   input  logic             wr_n,
   input  logic [LANES-1:0] byte_wr_n,
   input  logic             out_en_n,
   input  logic             lin_burst,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    dq_i,
   output logic [DW-1:0]    dq_o,
   output logic             dq_oe
);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sram_cmd_engine: DEPTH must be a power of two of at least 4");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("sram_cmd_engine: LANES and LANE_W must be positive");
   end

   burst_e           state_q;
   burst_e           state_nx;
   op_e              op;
   logic             load;
   logic             step;
   logic [AW-1:0]    eff_addr;
   logic             pend_vld;
   logic [AW-1:0]    pend_addr;
   logic [LANES-1:0] pend_be;
   logic             rd_vld;
   logic [DW-1:0]    rd_data;
   logic [DW-1:0]    rd_word;

   assign step = !clk_en_n;

   sram_cmd_decode #(.LANES(LANES)) u_dec (
      .clk_en_n (clk_en_n),
      .sel0_n   (sel0_n),
      .sel1     (sel1),
      .sel2_n   (sel2_n),
      .adv      (adv),
      .wr_n     (wr_n),
      .byte_wr_n(byte_wr_n),
      .out_en_n (out_en_n),
      .state    (state_q),
      .op       (op),
      .state_nx (state_nx),
      .load     (load)
   );

   sram_burst_seq #(.AW(AW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .load    (load),
      .lin     (lin_burst),
      .addr_in (addr),
      .eff_addr(eff_addr)
   );

   sram_lane_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_arr (
      .clk(clk),
      .we (step && pend_vld),
      .wa (pend_addr),
      .wbe(pend_be),
      .wd (dq_i),
      .ra (eff_addr),
      .rd (rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= BS_IDLE;
         rd_vld    <= 1'b0;
         rd_data   <= '0;
         pend_vld  <= 1'b0;
         pend_addr <= '0;
         pend_be   <= '0;
      end else if (step) begin
         state_q   <= state_nx;
         rd_vld    <= (op == OP_READ);
         if (op == OP_READ) rd_data <= rd_word;
         pend_vld  <= (op == OP_WRITE);
         pend_addr <= eff_addr;
         pend_be   <= ~byte_wr_n;
      end
   end

   assign dq_o  = rd_data;
   assign dq_oe = rd_vld && !out_en_n;

endmodule

// File: rtl/sram_cmd_engine_chk.sv
module sram_cmd_engine_chk
   import sram_eng_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int DW    = LANES * LANE_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clk_en_n,
   input logic             sel0_n,
   input logic             sel1,
   input logic             sel2_n,
   input logic             adv,
   input logic             wr_n,
   input logic [LANES-1:0] byte_wr_n,
   input logic             out_en_n,
   input logic [DW-1:0]    dq_o,
   input logic             dq_oe,
   input logic             rd_vld,
   input logic             pend_vld,
   input burst_e           state_q
);

   logic sel_ok;
   logic read_load;
   assign sel_ok    = !sel0_n && sel1 && !sel2_n;
   assign read_load = !clk_en_n && !adv && sel_ok && wr_n && !out_en_n;

   assert_no_spurious_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_vld && !read_load) |=> !rd_vld);

   assert_deselect_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv && !sel_ok) |=> !dq_oe);

   assert_abort_nostore_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv && sel_ok && !wr_n && (&byte_wr_n)) |=> !pend_vld);

   assert_dummy_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv && sel_ok && wr_n && out_en_n) |=> !rd_vld);

   assert_dummy_cont_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && adv && state_q == BS_DUMMY) |=> !rd_vld);

   assert_inhibit_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> ($stable(rd_vld) && $stable(dq_o) && $stable(pend_vld) && $stable(state_q)));

   assert_write_drv_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && ((!adv && sel_ok && !wr_n) || (adv && state_q == BS_WRITE))) |=> !dq_oe);

endmodule

bind sram_cmd_engine sram_cmd_engine_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/sram_cmd_engine_tb.sv
module sram_cmd_engine_tb;

   localparam int AW = 8;
   localparam int DW = 36;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          clk_en_n, sel0_n, sel1, sel2_n, adv, wr_n, out_en_n, lin_burst;
   logic [3:0]    byte_wr_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] dq_i;
   logic [DW-1:0] dq_o;
   logic          dq_oe;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] model [256];

   always #2 clk = ~clk;

   sram_cmd_engine u_dut (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel0_n(sel0_n), .sel1(sel1),
      .sel2_n(sel2_n), .adv(adv), .wr_n(wr_n), .byte_wr_n(byte_wr_n), .out_en_n(out_en_n),
      .lin_burst(lin_burst), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(int a, int salt);
      return DW'(a) * 36'h0_0101_0101 ^ DW'(salt) * 36'h9_3A5C_71E1;
   endfunction

   task automatic mwrite(int a, logic [DW-1:0] d, logic [3:0] be_n);
      for (int i = 0; i < 4; i++)
         if (!be_n[i]) model[a][i*9 +: 9] = d[i*9 +: 9];
   endtask

   task automatic drv_desel(int a);
      adv = 1'b0; sel0_n = 1'b1; sel1 = 1'b1; sel2_n = 1'b0; wr_n = 1'b1;
      byte_wr_n = 4'hF; addr = AW'(a);
   endtask

   task automatic drv_load(logic wr, int a, logic [3:0] be_n, logic oe_n);
      adv = 1'b0; sel0_n = 1'b0; sel1 = 1'b1; sel2_n = 1'b0; wr_n = ~wr;
      byte_wr_n = be_n; out_en_n = oe_n; addr = AW'(a);
   endtask

   task automatic do_write(int a, logic [DW-1:0] d, logic [3:0] be_n);
      drv_load(1'b1, a, be_n, 1'b0);
      tick();
      dq_i = d;
      drv_desel(0);
      tick();
      mwrite(a, d, be_n);
   endtask

   task automatic do_read(string tag, int a);
      drv_load(1'b0, a, 4'hF, 1'b0);
      tick();
      chk(tag, DW'(dq_oe), DW'(1));
      chk(tag, dq_o, model[a]);
      drv_desel(0);
      tick();
   endtask

   task automatic t_reset();
      chk("R1 reset oe", DW'(dq_oe), 0);
      out_en_n = 1'b0;
      adv = 1'b1; wr_n = 1'b1;
      tick(); tick();
      chk("R1 continue after reset oe", DW'(dq_oe), 0);
      drv_desel(0);
      tick();
      chk("R1 deselect oe", DW'(dq_oe), 0);
   endtask

   task automatic t_back_to_back();
      drv_load(1'b1, 0, 4'h0, 1'b0);
      for (int k = 0; k < 8; k++) begin
         tick();
         dq_i = pat(k, 1);
         mwrite(k, pat(k, 1), 4'h0);
         if (k < 7) drv_load(1'b1, k + 1, 4'h0, 1'b0);
         else       drv_load(1'b0, 0, 4'hF, 1'b0);
      end
      for (int k = 0; k < 8; k++) begin
         tick();
         chk("R3 R4 back-to-back oe", DW'(dq_oe), 1);
         chk("R3 R4 back-to-back data", dq_o, model[k]);
         if (k < 7) drv_load(1'b0, k + 1, 4'hF, 1'b0);
         else       drv_desel(0);
      end
      tick();
   endtask

   task automatic t_lanes();
      do_write(20, pat(20, 2), 4'h0);
      do_write(20, pat(20, 3), 4'b1010);
      do_read("R5 lanes 0 and 2", 20);
      do_write(20, pat(20, 4), 4'b0111);
      do_read("R5 lane 3 only", 20);
   endtask

   task automatic t_abort();
      drv_load(1'b1, 20, 4'hF, 1'b0);
      tick();
      chk("R6 abort oe", DW'(dq_oe), 0);
      dq_i = pat(20, 9);
      drv_desel(0);
      tick();
      do_read("R6 abort keeps word", 20);
   endtask

   task automatic t_dummy();
      drv_load(1'b0, 3, 4'hF, 1'b1);
      tick();
      out_en_n = 1'b0;
      #1;
      chk("R7 dummy load oe", DW'(dq_oe), 0);
      adv = 1'b1;
      tick();
      chk("R7 dummy continue 1 oe", DW'(dq_oe), 0);
      tick();
      chk("R7 dummy continue 2 oe", DW'(dq_oe), 0);
      drv_desel(0);
      tick();
   endtask

   task automatic t_burst();
      for (int a = 32; a < 36; a++) do_write(a, pat(a, 5), 4'h0);
      lin_burst = 1'b0;
      drv_load(1'b0, 33, 4'hF, 1'b0);
      for (int k = 0; k < 4; k++) begin
         tick();
         chk("R8 interleaved read", dq_o, model[32 + (1 ^ k)]);
         if (k < 3) begin adv = 1'b1; wr_n = 1'b0; byte_wr_n = 4'h0; end
         else drv_desel(0);
      end
      tick();
      lin_burst = 1'b1;
      drv_load(1'b0, 33, 4'hF, 1'b0);
      for (int k = 0; k < 4; k++) begin
         tick();
         chk("R8 linear read", dq_o, model[32 + ((1 + k) % 4)]);
         if (k < 3) begin adv = 1'b1; wr_n = 1'b0; end
         else drv_desel(0);
      end
      tick();
      drv_load(1'b1, 42, 4'h0, 1'b0);
      for (int k = 0; k < 4; k++) begin
         tick();
         dq_i = pat(k, 6);
         mwrite(40 + ((2 + k) % 4), pat(k, 6), 4'h0);
         if (k < 3) begin adv = 1'b1; wr_n = 1'b1; end
         else drv_desel(0);
      end
      tick();
      for (int a = 40; a < 44; a++) do_read("R8 linear write burst", a);
   endtask

   task automatic t_inhibit();
      do_write(60, pat(60, 7), 4'h0);
      drv_load(1'b0, 60, 4'hF, 1'b0);
      tick();
      clk_en_n = 1'b1;
      drv_load(1'b1, 61, 4'h0, 1'b0);
      tick(); tick();
      chk("R9 inhibit holds oe", DW'(dq_oe), 1);
      chk("R9 inhibit holds data", dq_o, model[60]);
      clk_en_n = 1'b0;
      drv_desel(0);
      tick();
      drv_load(1'b1, 62, 4'h0, 1'b0);
      tick();
      clk_en_n = 1'b1;
      dq_i = pat(62, 13);
      drv_desel(0);
      tick();
      chk("R9 inhibited write bus off", DW'(dq_oe), 0);
      clk_en_n = 1'b0;
      dq_i = pat(62, 8);
      tick();
      mwrite(62, pat(62, 8), 4'h0);
      do_read("R9 delayed write data", 62);
   endtask

   task automatic t_write_oe();
      drv_load(1'b0, 60, 4'hF, 1'b0);
      tick();
      chk("R10 read before write oe", DW'(dq_oe), 1);
      drv_load(1'b1, 63, 4'h0, 1'b0);
      tick();
      chk("R10 write turns drivers off", DW'(dq_oe), 0);
      dq_i = pat(63, 10);
      drv_desel(0);
      tick();
      mwrite(63, pat(63, 10), 4'h0);
   endtask

   task automatic t_oe_async();
      drv_load(1'b0, 63, 4'hF, 1'b0);
      tick();
      out_en_n = 1'b1;
      #1;
      chk("R11 oe high forces off", DW'(dq_oe), 0);
      out_en_n = 1'b0;
      #1;
      chk("R11 oe low restores", DW'(dq_oe), 1);
      chk("R11 held data", dq_o, model[63]);
      drv_desel(0);
      tick();
   endtask

   task automatic t_forward();
      do_write(70, pat(70, 11), 4'h0);
      drv_load(1'b1, 70, 4'b1100, 1'b0);
      tick();
      dq_i = pat(70, 12);
      mwrite(70, pat(70, 12), 4'b1100);
      drv_load(1'b0, 70, 4'hF, 1'b0);
      tick();
      chk("R12 forwarded write data", dq_o, model[70]);
      drv_desel(0);
      tick();
   endtask

   task automatic t_deselect();
      for (int s = 0; s < 3; s++) begin
         drv_load(1'b0, 60, 4'hF, 1'b0);
         tick();
         drv_load(1'b0, 60, 4'hF, 1'b0);
         if (s == 0) sel0_n = 1'b1;
         if (s == 1) sel1 = 1'b0;
         if (s == 2) sel2_n = 1'b1;
         tick();
         chk("R2 single select off", DW'(dq_oe), 0);
      end
      for (int a = 48; a < 52; a++) do_write(a, pat(a, 14), 4'h0);
      drv_desel(48);
      tick();
      adv = 1'b1; wr_n = 1'b0; byte_wr_n = 4'h0;
      for (int k = 0; k < 3; k++) begin
         dq_i = pat(k, 15);
         tick();
      end
      chk("R2 continue-deselect oe", DW'(dq_oe), 0);
      drv_desel(0);
      tick();
      for (int a = 48; a < 52; a++) do_read("R2 continue-deselect stores nothing", a);
   endtask

   initial begin
      rst_n = 1'b0; clk_en_n = 1'b0; out_en_n = 1'b0; lin_burst = 1'b1; dq_i = '0;
      drv_desel(0);
      for (int a = 0; a < 256; a++) model[a] = '0;
      tick(); tick();
      rst_n = 1'b1;
      #1;
      t_reset();
      t_back_to_back();
      t_lanes();
      t_abort();
      t_dummy();
      t_burst();
      t_inhibit();
      t_write_oe();
      t_oe_async();
      t_forward();
      t_deselect();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule